// File: doc/BRIEF.md
# Bipolar line code transmit encoder

This block turns a serial NRZ transmit bit stream into the two digital rail signals, positive and negative, that feed a DS3/E3-class line driver. A pulse on the positive rail stands for a positive line mark and a pulse on the negative rail for a negative mark. One encoder covers three line codes chosen by a mode input: plain alternate mark inversion (AMI), B3ZS, and HDB3. The two zero-substitution codes replace long runs of zeros with codewords that contain a bipolar violation, so that the far end can recover its clock.

The data passes through a short delay line whose length is the substitution window of the selected code. This lets a codeword rewrite zeros that have already been accepted but not yet sent. The last stage keeps track of the polarity of the last pulse. A bipolar violation (V) repeats that polarity, and every other mark (B) takes the opposite one. Three options act at the output: the rails can be launched from the falling clock edge instead of the rising one, both rails can be made active-low, and both rails can be forced to their inactive level when the line pins are disabled or the mode is not a bipolar one.

Top module: `bipolar_line_encoder`

## Requirements
- R1: With mode = 0 (AMI), each data 1 yields one pulse on the rail opposite to the previous pulse, and each data 0 yields no pulse. The first pulse after reset is positive.
- R2: With mode = 1 (B3ZS), each run of three zeros is sent as B0V if the number of B pulses since the last V is even (including zero after reset), and as 00V if it is odd.
- R3: With mode = 2 (HDB3), each run of four zeros is sent as B00V if the number of pulses since the last V is even, and as 000V if it is odd. The count restarts after every V.
- R4: A V pulse has the same polarity as the pulse before it. An inserted B pulse alternates like a data mark, and the pulse after a V is opposite to the V.
- R5: With clk_inv = 0, a bit sampled at rising edge k is seen on the rails just after rising edge k+W, where W = 1 for AMI, 3 for B3ZS and 4 for HDB3.
- R6: With clk_inv = 1, the rails take each new value at the falling edge that follows rising edge k+W. Between that rising edge and that falling edge they still show the previous value.
- R7: With rail_inv = 1, both rails are active-low. A pulse drives the rail to 0, and the idle level is 1.
- R8: When line_en = 0 or mode = 3, both rails stay at the inactive level (0, or 1 with rail_inv = 1) whatever the data.
- R9: The positive and negative rails are never active in the same cycle.
- R10: A synchronous reset sets the polarity back to positive-next, clears the parity count, and fills the delay line with idle slots. While reset is held, both rails are inactive. After reset, encoding starts exactly as from power-up, whatever was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Line code: 0 AMI, 1 B3ZS, 2 HDB3, 3 rails off |
| data_in | input | 1 | NRZ transmit data, sampled on the rising edge |
| line_en | input | 1 | Line pin enable; 0 forces both rails inactive |
| clk_inv | input | 1 | 1 launches the rails from the falling clock edge |
| rail_inv | input | 1 | 1 makes both rails active-low |
| pos_out | output | 1 | Positive rail |
| neg_out | output | 1 | Negative rail |

## Verification
Two things happen in the same clock cycle. The substitution decision at the head of the delay line can fire in the cycle where the tail stage emits a pulse whose polarity depends on what that decision writes. Runs of six or eight zeros provoke this, because the second codeword is written while the first one is still draining. The falling-edge launch and the rail inversion are combined with these runs. Each run is judged against a sequence-level model in the bench. Every output slot is compared after the rising edge, and also just before the falling edge to confirm which edge launched it.

// File: rtl/ble_pkg.sv
package ble_pkg;

   // line code selection as seen on the mode port
   typedef enum logic [1:0] {
      MODE_AMI  = 2'd0,
      MODE_B3ZS = 2'd1,
      MODE_HDB3 = 2'd2,
      MODE_OFF  = 2'd3
   } line_mode_e;

   // one slot of the delay line
   typedef enum logic [1:0] {
      SYM_IDLE = 2'd0,   // empty slot after reset, never counted as a zero
      SYM_ZERO = 2'd1,
      SYM_MARK = 2'd2,   // normal alternating pulse
      SYM_VIOL = 2'd3    // bipolar violation
   } sym_e;

   function automatic logic mode_is_bipolar(line_mode_e m);
      return (m != MODE_OFF);
   endfunction

endpackage

// File: rtl/ble_subst.sv
module ble_subst
   import ble_pkg::*;
#(
   parameter int B3_WIN = 3,
   parameter int HD_WIN = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  line_mode_e mode,
   input  logic       data_in,
   output sym_e       sym_out
);

   localparam int DEPTH = (HD_WIN > B3_WIN) ? HD_WIN : B3_WIN;
   localparam int TW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (B3_WIN < 2 || HD_WIN < 2) begin : g_bad_window
         $error("substitution windows must be at least two bits");
      end
   endgenerate

   sym_e             slot_q [DEPTH];
   sym_e             slot_d [DEPTH];
   logic [DEPTH-1:0] is_zero;
   logic [DEPTH-1:0] run_ok;
   logic [TW-1:0]    tap;
   logic             odd_q;
   logic             fire;

   // run_ok[i]: the i newest slots all hold real zeros
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_run
         assign is_zero[i] = (slot_q[i] == SYM_ZERO);
         if (i == 0) begin : g_first
            assign run_ok[i] = 1'b1;
         end else begin : g_rest
            assign run_ok[i] = &is_zero[i-1:0];
         end
      end
   endgenerate

   // output tap = window length minus one
   always_comb begin
      case (mode)
         MODE_B3ZS: tap = TW'(B3_WIN - 1);
         MODE_HDB3: tap = TW'(HD_WIN - 1);
         default:   tap = '0;
      endcase
   end

   assign fire = (tap != '0) && !data_in && run_ok[tap];

   always_comb begin
      slot_d[0] = data_in ? SYM_MARK : (fire ? SYM_VIOL : SYM_ZERO);
      for (int i = 1; i < DEPTH; i++) begin
         slot_d[i] = slot_q[i-1];
      end
      if (fire && !odd_q) begin
         slot_d[tap] = SYM_MARK;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            slot_q[i] <= SYM_IDLE;
         end
         odd_q <= 1'b0;
      end else begin
         slot_q <= slot_d;
         if (data_in) begin
            odd_q <= ~odd_q;
         end else if (fire) begin
            odd_q <= 1'b0;
         end
      end
   end

   assign sym_out = slot_q[tap];

   // R1
   mark_entry_chk: assert property (@(posedge clk) disable iff (rst)
      data_in |=> (slot_q[0] == SYM_MARK));

   // R2
   zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (!data_in && slot_q[0] == SYM_MARK) |=> (slot_q[0] != SYM_MARK));

endmodule

// File: rtl/ble_alternator.sv
module ble_alternator
   import ble_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  sym_e sym_in,
   output logic rail_p,
   output logic rail_n
);

   logic last_pos_q;   // 1: the previous pulse was positive

   always_ff @(posedge clk) begin
      if (rst) begin
         rail_p     <= 1'b0;
         rail_n     <= 1'b0;
         last_pos_q <= 1'b0;
      end else begin
         case (sym_in)
            SYM_MARK: begin
               rail_p     <= ~last_pos_q;
               rail_n     <= last_pos_q;
               last_pos_q <= ~last_pos_q;
            end
            SYM_VIOL: begin
               rail_p <= last_pos_q;
               rail_n <= ~last_pos_q;
            end
            default: begin
               rail_p <= 1'b0;
               rail_n <= 1'b0;
            end
         endcase
      end
   end

   // R1
   mark_flips_chk: assert property (@(posedge clk) disable iff (rst)
      (sym_in == SYM_MARK && last_pos_q) |=> (rail_n && !rail_p));

   // R4
   viol_repeats_chk: assert property (@(posedge clk) disable iff (rst)
      (sym_in == SYM_VIOL && last_pos_q) |=> (rail_p && !rail_n));

   // R1
   space_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (sym_in == SYM_ZERO || sym_in == SYM_IDLE) |=> (!rail_p && !rail_n));

   // R9
   one_rail_chk: assert property (@(posedge clk) disable iff (rst)
      !(rail_p && rail_n));

endmodule

// File: rtl/ble_launch.sv
module ble_launch #(
   parameter bit FALL_OPT = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic clk_inv,
   input  logic rise_p,
   input  logic rise_n,
   input  logic drive_en,
   input  logic rail_inv,
   output logic pos_out,
   output logic neg_out
);

   logic sel_p;
   logic sel_n;

   generate
      if (FALL_OPT) begin : g_fall
         logic fall_p_q;
         logic fall_n_q;

         always_ff @(negedge clk) begin
            if (rst) begin
               fall_p_q <= 1'b0;
               fall_n_q <= 1'b0;
            end else begin
               fall_p_q <= rise_p;
               fall_n_q <= rise_n;
            end
         end

         assign sel_p = clk_inv ? fall_p_q : rise_p;
         assign sel_n = clk_inv ? fall_n_q : rise_n;

         // R6
         fall_tracks_chk: assert property (@(posedge clk) disable iff (rst)
            (clk_inv && drive_en) |-> (pos_out == (rise_p ^ rail_inv)));
      end else begin : g_rise
         assign sel_p = rise_p;
         assign sel_n = rise_n;
      end
   endgenerate

   assign pos_out = (drive_en & sel_p) ^ rail_inv;
   assign neg_out = (drive_en & sel_n) ^ rail_inv;

   // R8
   idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !drive_en |-> (pos_out == rail_inv && neg_out == rail_inv));

endmodule

// File: rtl/bipolar_line_encoder.sv
module bipolar_line_encoder
   import ble_pkg::*;
#(
   parameter int B3_WIN   = 3,
   parameter int HD_WIN   = 4,
   parameter bit FALL_OPT = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] mode,
   input  logic       data_in,
   input  logic       line_en,
   input  logic       clk_inv,
   input  logic       rail_inv,
   output logic       pos_out,
   output logic       neg_out
);

   line_mode_e mode_e;
   sym_e       tap_sym;
   logic       rail_p;
   logic       rail_n;
   logic       drive_en;

   assign mode_e   = line_mode_e'(mode);
   assign drive_en = line_en & mode_is_bipolar(mode_e);

   ble_subst #(
      .B3_WIN (B3_WIN),
      .HD_WIN (HD_WIN)
   ) u_subst (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode_e),
      .data_in (data_in),
      .sym_out (tap_sym)
   );

   ble_alternator u_alt (
      .clk    (clk),
      .rst    (rst),
      .sym_in (tap_sym),
      .rail_p (rail_p),
      .rail_n (rail_n)
   );

   ble_launch #(
      .FALL_OPT (FALL_OPT)
   ) u_launch (
      .clk      (clk),
      .rst      (rst),
      .clk_inv  (clk_inv),
      .rise_p   (rail_p),
      .rise_n   (rail_n),
      .drive_en (drive_en),
      .rail_inv (rail_inv),
      .pos_out  (pos_out),
      .neg_out  (neg_out)
   );

   // R9
   rails_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !((pos_out ^ rail_inv) && (neg_out ^ rail_inv)));

endmodule

// File: tb/bipolar_line_encoder_bench.sv
`timescale 1ns/100ps
module bipolar_line_encoder_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode = 2'd0;
   logic       data_in = 1'b0;
   logic       line_en = 1'b1;
   logic       clk_inv = 1'b0;
   logic       rail_inv = 1'b0;
   wire        pos_out;
   wire        neg_out;

   bipolar_line_encoder u_bipolar_line_encoder (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode),
      .data_in  (data_in),
      .line_en  (line_en),
      .clk_inv  (clk_inv),
      .rail_inv (rail_inv),
      .pos_out  (pos_out),
      .neg_out  (neg_out)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    due;
      logic  p;
      logic  n;
      string tag;
   } item_t;

   item_t sbq[$];
   item_t cur;
   int    n_chk = 0;
   int    n_bad = 0;
   logic  early_p, early_n;
   logic  last_p = 1'b0, last_n = 1'b0;

   task automatic check(input string tag, input logic ap, input logic an,
                        input logic ep, input logic en);
      n_chk++;
      if (ap !== ep || an !== en) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: got p=%b n=%b, expected p=%b n=%b",
                  tag, cyc, ap, an, ep, en);
      end
   endtask

   // monitor: pops expected slots when they fall due
   initial begin
      forever begin
         @(posedge clk);
         #1;
         early_p = pos_out;
         early_n = neg_out;
         #3;
         while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            cur = sbq.pop_front();
            if (cur.due < cyc) begin
               n_chk++;
               n_bad++;
               $display("FAIL %s: slot due %0d missed, got p=%b n=%b, expected p=%b n=%b",
                        cur.tag, cur.due, pos_out, neg_out, cur.p, cur.n);
            end else begin
               check(cur.tag, pos_out, neg_out, cur.p, cur.n);
               // R9: never both active
               check("R9 exclusive", (pos_out ^ rail_inv) && (neg_out ^ rail_inv), 1'b0,
                     1'b0, 1'b0);
               if (cur.p !== last_p || cur.n !== last_n) begin
                  if (clk_inv)
                     check("R6 old value before falling edge", early_p, early_n, last_p, last_n);
                  else
                     check("R5 new value after rising edge", early_p, early_n, cur.p, cur.n);
               end
               last_p = cur.p;
               last_n = cur.n;
            end
         end
      end
   end

   // driver: reset, model the whole sequence, drive it and queue the expected slots
   task automatic run_seq(input string tag, input logic [1:0] md, input string bits,
                          input logic en, input logic inv, input logic cinv);
      int w;
      int n;
      int total;
      int sy[64];
      int par;
      int zr;
      int lastpol;
      int pol;
      item_t it;
      w = (md == 2'd1) ? 3 : ((md == 2'd2) ? 4 : 1);
      n = bits.len();
      total = n + w + 2;
      par = 0;
      zr = 0;
      for (int i = 0; i < total; i++) begin
         if (i < n && bits[i] == 8'h31) begin
            sy[i] = 1;
            par = 1 - par;
            zr = 0;
         end else begin
            sy[i] = 0;
            zr++;
            if (w > 1 && zr == w) begin
               sy[i] = 2;
               if (par == 0) sy[i-w+1] = 1;
               par = 0;
               zr = 0;
            end
         end
      end
      // reset window
      @(posedge clk);
      #2;
      rst = 1'b1;
      mode = md;
      line_en = en;
      rail_inv = inv;
      clk_inv = cinv;
      data_in = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #2;
      // R10: rails inactive while reset is held
      check("R10 idle in reset", pos_out, neg_out, inv, inv);
      last_p = inv;
      last_n = inv;
      lastpol = -1;
      rst = 1'b0;
      for (int i = 0; i < total; i++) begin
         data_in = (i < n) && (bits[i] == 8'h31);
         if (i < n) begin
            if (sy[i] == 1) begin
               lastpol = -lastpol;
               pol = lastpol;
            end else if (sy[i] == 2) begin
               pol = lastpol;
            end else begin
               pol = 0;
            end
            it.due = cyc + 1 + w;
            it.p = ((en && md != 2'd3) ? (pol == 1) : 1'b0) ^ inv;
            it.n = ((en && md != 2'd3) ? (pol == -1) : 1'b0) ^ inv;
            it.tag = tag;
            sbq.push_back(it);
         end
         @(posedge clk);
         #2;
      end
      data_in = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #1000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang, expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1: AMI alternation
      run_seq("R1 ami", 2'd0, "11010011100010111", 1'b1, 1'b0, 1'b0);
      // R2 R4: B3ZS even/odd codewords, back-to-back runs
      run_seq("R2 R4 b3zs", 2'd1, "000100011000000010110000000001", 1'b1, 1'b0, 1'b0);
      // R3 R4: HDB3 even/odd codewords, back-to-back runs
      run_seq("R3 R4 hdb3", 2'd2, "0000100001100000000101000001110000", 1'b1, 1'b0, 1'b0);
      // R7: active-low rails on HDB3
      run_seq("R7 inverted hdb3", 2'd2, "1000011000000001000", 1'b1, 1'b1, 1'b0);
      // R6: falling-edge launch on B3ZS
      run_seq("R6 fall b3zs", 2'd1, "100000010001100000", 1'b1, 1'b0, 1'b1);
      // R6 R7: falling edge together with inversion on AMI
      run_seq("R6 R7 fall inv ami", 2'd0, "1101100101", 1'b1, 1'b1, 1'b1);
      // R8: line pins disabled
      run_seq("R8 disabled", 2'd1, "1110001011000", 1'b0, 1'b0, 1'b0);
      // R8: disabled with inversion keeps idle high
      run_seq("R8 disabled inv", 2'd0, "101111", 1'b0, 1'b1, 1'b0);
      // R8: mode 3 keeps rails off
      run_seq("R8 mode off", 2'd3, "11011101", 1'b1, 1'b0, 1'b0);
      // R10: leave polarity odd, then reset must restart positive-next
      run_seq("R10 pre", 2'd0, "1", 1'b1, 1'b0, 1'b0);
      run_seq("R10 restart ami", 2'd0, "1001", 1'b1, 1'b0, 1'b0);
      // R10: leave parity odd with zeros in flight, then reset
      run_seq("R10 pre b3zs", 2'd1, "100", 1'b1, 1'b0, 1'b0);
      run_seq("R10 restart b3zs", 2'd1, "0001", 1'b1, 1'b0, 1'b0);
      // R5: latency check on plain rising-edge launch, HDB3
      run_seq("R5 hdb3 latency", 2'd2, "1100001", 1'b1, 1'b0, 1'b0);
      repeat (12) @(posedge clk);
      if (sbq.size() != 0) begin
         n_chk++;
         n_bad++;
         $display("FAIL R5: %0d slots never checked, expected 0", sbq.size());
      end
      summary();
      $finish;
   end

endmodule